// File: doc/BRIEF.md
# Conditional Register Transfer Unit

This block is a small register datapath with one destination register and three source registers, all eight bits wide. On each rising clock edge the destination register may be rewritten with an arithmetic result. Two Boolean control functions decide whether that happens and which result is used. Seven single-bit control inputs feed those two functions. One function selects a difference of two sources, and the other selects a sum of a different pair.

The subtract path and the add path share a single ripple adder. For subtraction, the second operand is inverted and the carry-in is forced to one. A source multiplexer picks the second operand, and one load enable gates the destination register. The carry out of the adder is stored next to the result, so it can be read as a carry on addition and as a "no borrow" indication on subtraction. The three source registers are written through a common data port with one load strobe per register, which allows test values to be placed before a transfer.

Top module: `cond_xfer_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `dst_q`, `srca_q`, `srcb_q`, `srcc_q` and `carry_q` all become 0 on that edge.
- R2: When the subtract function `x | y | z | (a & b)` is true at an edge, `dst_q` becomes `(srca_q - srcb_q) mod 256`, using the register values from before that edge.
- R3: When the add function `(a & b & c) | d` is true and the subtract function is false, `dst_q` becomes `(srca_q + srcc_q) mod 256`.
- R4: When both functions are true in the same cycle, the subtraction of R2 is performed and the addition is ignored.
- R5: When neither function is true, `dst_q` and `carry_q` keep their values.
- R6: Each time `dst_q` is written, `carry_q` takes bit 8 of the 9-bit adder result. For an addition this is the carry of `srca_q + srcc_q`. For a subtraction it is the carry of `srca_q + ~srcb_q + 1`, which is 1 exactly when `srca_q >= srcb_q`.
- R7: A high `ld_a`, `ld_b` or `ld_c` writes `ld_data` into `srca_q`, `srcb_q` or `srcc_q` respectively on the edge. A register whose strobe is low keeps its value. A transfer in the same cycle uses the values from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x | input | 1 | Control term of the subtract function |
| y | input | 1 | Control term of the subtract function |
| z | input | 1 | Control term of the subtract function |
| a | input | 1 | Control term shared by both functions |
| b | input | 1 | Control term shared by both functions |
| c | input | 1 | Control term of the add function |
| d | input | 1 | Control term of the add function |
| ld_a | input | 1 | Load strobe for source register A |
| ld_b | input | 1 | Load strobe for source register B |
| ld_c | input | 1 | Load strobe for source register C |
| ld_data | input | 8 | Data written by the load strobes |
| dst_q | output | 8 | Destination register |
| srca_q | output | 8 | Source register A (minuend / first addend) |
| srcb_q | output | 8 | Source register B (subtrahend) |
| srcc_q | output | 8 | Source register C (second addend) |
| carry_q | output | 1 | Stored adder carry from the last write of `dst_q` |

## Verification
The assertions are checked on every cycle. They cover:
- the reset clearing;
- the difference and sum written for each control function;
- subtraction winning when both functions are true;
- holding when neither function is true;
- the stored carry;
- the loads of the source registers.

Only the bench scenarios can show that these rules combine correctly over long runs. Examples are a chain of transfers where each result depends on earlier loads and results, and the specific wrap and borrow corners: a difference that goes below zero, a sum that overflows to zero, and equal operands. Those cases are driven on purpose so that their values and carries are seen.

// File: rtl/cxu_pkg.sv
// Shared types for the conditional register transfer unit.
// Assumes: the operation encoding is used only inside the unit.
package cxu_pkg;
    typedef enum logic [1:0] {
        XFER_HOLD = 2'd0,
        XFER_ADD  = 2'd1,
        XFER_SUB  = 2'd2
    } xfer_op_e;
endpackage

// File: rtl/cxu_ctrl_decode.sv
// Evaluates the two Boolean control functions and resolves them into one
// operation. Subtraction wins when both functions are true.
// Assumes: the control inputs are synchronous to the clock of the unit.
module cxu_ctrl_decode
    import cxu_pkg::*;
(
    input  logic     x,
    input  logic     y,
    input  logic     z,
    input  logic     a,
    input  logic     b,
    input  logic     c,
    input  logic     d,
    output xfer_op_e op
);
    logic fn_sub;
    logic fn_add;

    // Purpose: the two control functions.
    always_comb begin
        fn_sub = x | y | z | (a & b);
        fn_add = (a & b & c) | d;
    end

    // Purpose: priority resolution, subtraction first.
    always_comb begin
        if (fn_sub)      op = XFER_SUB;
        else if (fn_add) op = XFER_ADD;
        else             op = XFER_HOLD;
    end
endmodule

// File: rtl/cxu_addsub.sv
// Ripple-carry adder/subtractor. When sub is high, opnd_b is inverted and
// the carry-in is 1, so the result is opnd_a minus opnd_b in two's complement.
// Assumes: unsigned operands; the result wraps modulo 2**W.
module cxu_addsub #(
    parameter int W = 8
) (
    input  logic         sub,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: one full-adder cell of the ripple chain.
        always_comb begin
            b_eff[i]    = opnd_b[i] ^ sub;
            sum[i]      = opnd_a[i] ^ b_eff[i] ^ chain[i];
            chain[i+1]  = (opnd_a[i] & b_eff[i]) | (chain[i] & (opnd_a[i] ^ b_eff[i]));
        end
    end

    assign cout = chain[W];
endmodule

// File: rtl/cxu_reg.sv
// Register with load enable and synchronous active-low clear.
// Assumes: rst_n is synchronous to clk.
module cxu_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, otherwise load when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/cond_xfer_unit.sv
// Conditional register transfer unit. On each edge the destination register
// takes A-B or A+C, as chosen by two control functions, and the carry out is
// stored beside it. Three source registers are loaded from a common port.
// Assumes: a single clock; synchronous active-low reset.
module cond_xfer_unit
    import cxu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x,
    input  logic              y,
    input  logic              z,
    input  logic              a,
    input  logic              b,
    input  logic              c,
    input  logic              d,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              ld_c,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] dst_q,
    output logic [DATA_W-1:0] srca_q,
    output logic [DATA_W-1:0] srcb_q,
    output logic [DATA_W-1:0] srcc_q,
    output logic              carry_q
);
    localparam int NUM_SRC = 3;

    xfer_op_e                  op;
    logic                      sub_mode;
    logic                      dst_en;
    logic [DATA_W-1:0]         opnd_sel;
    logic [DATA_W-1:0]         result;
    logic                      cout;
    logic [NUM_SRC-1:0]        src_ld;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_q;

    cxu_ctrl_decode u_dec (
        .x(x), .y(y), .z(z), .a(a), .b(b), .c(c), .d(d), .op(op)
    );

    // Purpose: operand multiplexer and destination load enable.
    always_comb begin
        sub_mode = (op == XFER_SUB);
        dst_en   = (op != XFER_HOLD);
        opnd_sel = sub_mode ? src_q[1] : src_q[2];
    end

    cxu_addsub #(.W(DATA_W)) u_alu (
        .sub    (sub_mode),
        .opnd_a (src_q[0]),
        .opnd_b (opnd_sel),
        .sum    (result),
        .cout   (cout)
    );

    assign src_ld = {ld_c, ld_b, ld_a};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        cxu_reg #(.W(DATA_W)) u_src (
            .clk(clk), .rst_n(rst_n), .en(src_ld[s]), .d(ld_data), .q(src_q[s])
        );
    end

    cxu_reg #(.W(DATA_W + 1)) u_dst (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (dst_en),
        .d     ({cout, result}),
        .q     ({carry_q, dst_q})
    );

    assign srca_q = src_q[0];
    assign srcb_q = src_q[1];
    assign srcc_q = src_q[2];
endmodule

// File: rtl/cxu_checker.sv
// Property checker for cond_xfer_unit, attached by bind.
// Assumes: the same clock and reset as the unit.
module cxu_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              x,
    input logic              y,
    input logic              z,
    input logic              a,
    input logic              b,
    input logic              c,
    input logic              d,
    input logic              ld_a,
    input logic              ld_b,
    input logic              ld_c,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] dst_q,
    input logic [DATA_W-1:0] srca_q,
    input logic [DATA_W-1:0] srcb_q,
    input logic [DATA_W-1:0] srcc_q,
    input logic              carry_q
);
    logic            want_sub;
    logic            want_add;
    logic [DATA_W:0] exp_add;
    logic [DATA_W:0] exp_sub;

    // Purpose: reference functions and wide results for the properties.
    always_comb begin
        want_sub = x | y | z | (a & b);
        want_add = (a & b & c) | d;
        exp_add  = {1'b0, srca_q} + {1'b0, srcc_q};
        exp_sub  = {1'b0, srca_q} + {1'b0, ~srcb_q} + {{DATA_W{1'b0}}, 1'b1};
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dst_q == '0 && srca_q == '0 && srcb_q == '0 && srcc_q == '0 && !carry_q));

    // R2 and R4: subtraction whenever its function is true
    assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        want_sub |=> dst_q == $past(exp_sub[DATA_W-1:0]));

    assert_add_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (want_add && !want_sub) |=> dst_q == $past(exp_add[DATA_W-1:0]));

    assert_sub_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (want_add && want_sub) |=> carry_q == $past(exp_sub[DATA_W]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!want_add && !want_sub) |=> ($stable(dst_q) && $stable(carry_q)));

    assert_carry_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (want_add && !want_sub) |=> carry_q == $past(exp_add[DATA_W]));

    assert_carry_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
        want_sub |=> carry_q == $past(exp_sub[DATA_W]));

    assert_load_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a |=> srca_q == $past(ld_data));

    assert_load_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_b |=> srcb_q == $past(ld_data));

    assert_keep_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_c |=> $stable(srcc_q));
endmodule

bind cond_xfer_unit cxu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .x(x), .y(y), .z(z), .a(a), .b(b), .c(c), .d(d),
    .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .ld_data(ld_data),
    .dst_q(dst_q), .srca_q(srca_q), .srcb_q(srcb_q), .srcc_q(srcc_q),
    .carry_q(carry_q)
);

// File: tb/test_cond_xfer_unit.sv
// Self-checking bench: directed corners followed by seeded random cycles,
// compared against a bench-side model of the requirements.
module test_cond_xfer_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         x = 0, y = 0, z = 0, a = 0, b = 0, c = 0, d = 0;
    logic         ld_a = 0, ld_b = 0, ld_c = 0;
    logic [W-1:0] ld_data = '0;
    logic [W-1:0] dst_q, srca_q, srcb_q, srcc_q;
    logic         carry_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] m_dst = '0, m_a = '0, m_b = '0, m_c = '0;
    logic         m_cy = 1'b0;

    always #4 clk = ~clk;

    cond_xfer_unit #(.DATA_W(W)) i_cond_xfer_unit (
        .clk(clk), .rst_n(rst_n), .x(x), .y(y), .z(z), .a(a), .b(b), .c(c), .d(d),
        .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .ld_data(ld_data),
        .dst_q(dst_q), .srca_q(srca_q), .srcb_q(srcb_q), .srcc_q(srcc_q),
        .carry_q(carry_q)
    );

    function automatic logic [W:0] calc(input logic [W-1:0] p, input logic [W-1:0] q,
                                        input bit sub);
        if (sub) return {1'b0, p} + {1'b0, ~q} + 1;
        return {1'b0, p} + {1'b0, q};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: update the model from the current inputs, then compare after the edge.
    task automatic cycle();
        bit fs, fa;
        logic [W:0] r;
        string tag;
        fs = x | y | z | (a & b);
        fa = (a & b & c) | d;
        tag = !rst_n ? "R1" : (fs && fa) ? "R4" : fs ? "R2" : fa ? "R3" : "R5";
        if (!rst_n) begin
            m_dst = '0; m_a = '0; m_b = '0; m_c = '0; m_cy = 1'b0;
        end else begin
            if (fs)      begin r = calc(m_a, m_b, 1'b1); {m_cy, m_dst} = r; end
            else if (fa) begin r = calc(m_a, m_c, 1'b0); {m_cy, m_dst} = r; end
            if (ld_a) m_a = ld_data;
            if (ld_b) m_b = ld_data;
            if (ld_c) m_c = ld_data;
        end
        @(posedge clk);
        #1;
        chk({tag, " dst"}, 32'(dst_q), 32'(m_dst));
        chk(!rst_n ? "R1 carry" : "R6 carry", 32'(carry_q), 32'(m_cy));
        chk(!rst_n ? "R1 srca" : "R7 srca", 32'(srca_q), 32'(m_a));
        chk(!rst_n ? "R1 srcb" : "R7 srcb", 32'(srcb_q), 32'(m_b));
        chk(!rst_n ? "R1 srcc" : "R7 srcc", 32'(srcc_q), 32'(m_c));
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic [6:0] v);
        {x, y, z, a, b, c, d} = v;
    endtask

    task automatic load(input logic [2:0] which, input logic [W-1:0] v);
        set_ctl(7'b0);
        {ld_c, ld_b, ld_a} = which;
        ld_data = v;
        cycle();
        {ld_c, ld_b, ld_a} = 3'b000;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cycle();                          // R1: reset state
        rst_n = 1'b1;
        load(3'b001, 8'h10);              // R7 load A
        load(3'b010, 8'h20);              // R7 load B
        set_ctl(7'b1000000); cycle();     // R2: 0x10-0x20 wraps to 0xF0, carry 0
        set_ctl(7'b0000000); cycle();     // R5: hold
        load(3'b100, 8'hF0);              // R7 load C
        set_ctl(7'b0000001); cycle();     // R3: 0x10+0xF0 = 0x00, carry 1
        set_ctl(7'b0001111); cycle();     // R4: both true, subtraction wins
        load(3'b010, 8'h10);
        set_ctl(7'b0010000); cycle();     // R2/R6: equal operands, 0 with carry 1
        set_ctl(7'b0001100); ld_a = 1; ld_data = 8'h55; cycle(); // R7: old A used
        ld_a = 0;
        for (int i = 0; i < 400; i++) begin
            x = ($urandom % 5) == 0; y = ($urandom % 6) == 0; z = ($urandom % 6) == 0;
            a = $urandom % 2; b = $urandom % 2; c = $urandom % 2; d = ($urandom % 3) == 0;
            ld_a = $urandom % 2; ld_b = $urandom % 2; ld_c = $urandom % 2;
            ld_data = W'($urandom);
            rst_n = ($urandom % 60) != 0;
            cycle();
        end
        rst_n = 1'b0; set_ctl(7'b1111111); cycle();   // R1: reset beats control
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule